// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

A 32-bit processor core that completes every instruction in one clock cycle. It executes five register-to-register operations (add, sub, and, or, set-on-less-than), a word load, a word store and a branch-if-equal. The core holds the program counter, a 32-entry register file, a sign extender, the instruction decoder, the ALU-operation decoder, the ALU, and two dedicated adders: one for the sequential PC and one for the branch target.

Instruction and data storage sit outside the core as two separate word-addressed arrays, reached through combinational read ports. The core presents byte addresses, and the word index is address bits [..:2]. Data writes happen on the rising clock edge while the write strobe is high. The control path has two levels. The instruction decoder turns the opcode into datapath selects and a 2-bit operation class. A second decoder combines that class with the funct field to give a 4-bit ALU code. All control is combinational. Only the PC, the register file and data-memory writes change at a clock edge.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low the instruction address is 0. Reset is applied asynchronously and released synchronously through a two-flop stage.
- R2: An instruction that is not a taken branch sets the next PC to PC+4.
- R3: Opcode 000000 is register-register. The funct values are add=100000, sub=100010, and=100100 and or=100101, and the result is written to rd (bits 15:11). The ALU codes are AND=0000, OR=0001, ADD=0010, SUB=0110 and SLT=0111.
- R4: Funct 101010 (slt) writes 1 to rd when rs is less than rt as signed two's-complement values, and writes 0 otherwise.
- R5: Opcode 100011 (lw) writes the data word at byte address rs + sign-extended imm16 into rt (bits 20:16).
- R6: Opcode 101011 (sw) writes rt to the data word at byte address rs + sign-extended imm16. The data write strobe is high only for this opcode.
- R7: Opcode 000100 (beq) sets the next PC to PC+4 + (sign-extended imm16 << 2) when rs equals rt, and to PC+4 otherwise. It writes no register and no memory.
- R8: Register 0 always reads as zero, and writes to it are dropped.
- R9: Any other opcode writes no register and no memory, and only advances the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data byte address (ALU result) |
| dmem_wdata | output | 32 | Store data (rt) |
| dmem_we | output | 1 | Data write strobe, taken at the rising edge |
| dmem_re | output | 1 | Data read qualifier, high for loads |
| dmem_rdata | input | 32 | Data word at `dmem_addr` |

## Verification
The bench builds the core with its default 32-bit width and 32 registers. It attaches a 32-word instruction array and a 16-word data array, which keep every address the program uses in a small window. One fixed program exercises every instruction class, a register-0 write, an unknown opcode aimed at a sentinel word, a load with a negative offset, and a backward branch that halts. The bench reruns that program from reset for every ordered pair drawn from eight edge operands (zero, one, all-ones, the two signed extremes, and mixed patterns). That gives 64 runs. Every ALU result, both slt orderings, and both the taken and not-taken branch outcomes are compared with values the bench computes itself.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned REG_AW = 5;

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_MEM   = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_FUNCT = 2'b10
  } op_class_e;

  typedef struct packed {
    logic      dst_rd;
    logic      reg_we;
    logic      src_imm;
    logic      mem_re;
    logic      mem_we;
    logic      wb_mem;
    logic      branch;
    op_class_e cls;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_op_e    alu_op
);
  always_comb begin
    ctrl = '{dst_rd: 1'b0, reg_we: 1'b0, src_imm: 1'b0, mem_re: 1'b0,
             mem_we: 1'b0, wb_mem: 1'b0, branch: 1'b0, cls: CLS_MEM};
    unique case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        ctrl.cls    = CLS_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.reg_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.mem_re  = 1'b1;
        ctrl.wb_mem  = 1'b1;
      end
      OPC_STORE: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.cls    = CLS_BRANCH;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (ctrl.cls)
      CLS_MEM:    alu_op = ALU_ADD;
      CLS_BRANCH: alu_op = ALU_SUB;
      default: begin
        unique case (funct)
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          default: alu_op = ALU_ADD;
        endcase
      end
    endcase
  end

  // R3: memory class always adds, branch class always subtracts
  always_comb begin
    a_r3_class_forces_op: assert (!(ctrl.cls == CLS_MEM && alu_op != ALU_ADD) &&
                                  !(ctrl.cls == CLS_BRANCH && alu_op != ALU_SUB));
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned REGS = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [sc_pkg::REG_AW-1:0] waddr,
  input  logic [XLEN-1:0]          wdata,
  input  logic [sc_pkg::REG_AW-1:0] raddr_a,
  input  logic [sc_pkg::REG_AW-1:0] raddr_b,
  output logic [XLEN-1:0]          rdata_a,
  output logic [XLEN-1:0]          rdata_b
);
  logic [XLEN-1:0] regs_q [REGS];

  for (genvar g = 1; g < REGS; g++) begin : g_reg
    logic en;
    assign en = we && (waddr == g[sc_pkg::REG_AW-1:0]);
    always_ff @(posedge clk) begin
      if (en) regs_q[g] <= wdata;
    end
  end
  assign regs_q[0] = '0;

  assign rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];

  // R8: register 0 reads as zero on both ports
  always_comb begin
    a_r8_zero_reg: assert (!(raddr_a == '0 && rdata_a != '0) &&
                           !(raddr_b == '0 && rdata_b != '0));
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  logic [XLEN-1:0] diff;
  logic            lt;

  assign diff = a - b;
  assign lt   = (a[XLEN-1] != b[XLEN-1]) ? a[XLEN-1] : diff[XLEN-1];

  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, lt};
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);

  // R4: set-on-less-than yields only 0 or 1
  always_comb begin
    a_r4_slt_boolean: assert (!(op == ALU_SLT && y[XLEN-1:1] != '0));
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned REGS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  output logic            dmem_re,
  input  logic [XLEN-1:0] dmem_rdata
);
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [XLEN-1:0] pc_q, pc_d, pc_seq, br_target, imm_ext;
  logic [5:0]      opcode, funct;
  logic [REG_AW-1:0] rs, rt, rd, wsel;
  ctrl_t           ctrl;
  alu_op_e         alu_op;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, wb_data;
  logic            alu_zero, take_br, rf_we;

  assign opcode  = imem_data[31:26];
  assign rs      = imem_data[25:21];
  assign rt      = imem_data[20:16];
  assign rd      = imem_data[15:11];
  assign funct   = imem_data[5:0];
  assign imm_ext = {{(XLEN-16){imem_data[15]}}, imem_data[15:0]};

  sc_ctrl u_ctrl (.opcode(opcode), .funct(funct), .ctrl(ctrl), .alu_op(alu_op));

  assign wsel  = ctrl.dst_rd ? rd : rt;
  assign rf_we = ctrl.reg_we && rst_sync_n;

  sc_regfile #(.XLEN(XLEN), .REGS(REGS)) u_rf (
    .clk(clk), .we(rf_we), .waddr(wsel), .wdata(wb_data),
    .raddr_a(rs), .raddr_b(rt), .rdata_a(rs_val), .rdata_b(rt_val)
  );

  assign alu_b = ctrl.src_imm ? imm_ext : rt_val;

  sc_alu #(.XLEN(XLEN)) u_alu (
    .op(alu_op), .a(rs_val), .b(alu_b), .y(alu_y), .zero(alu_zero)
  );

  assign wb_data    = ctrl.wb_mem ? dmem_rdata : alu_y;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we && rst_sync_n;
  assign dmem_re    = ctrl.mem_re;

  assign pc_seq    = pc_q + XLEN'(4);
  assign br_target = pc_seq + {imm_ext[XLEN-3:0], 2'b00};
  assign take_br   = ctrl.branch && alu_zero;

  always_comb begin
    pc_d = pc_seq;
    if (take_br) pc_d = br_target;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc_q <= '0;
    else if (rst_sync_n) pc_q <= pc_d;
  end
  assign imem_addr = pc_q;

  // R2: a non-branching step advances by one word
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (opcode != OPC_BEQ) |=> (pc_q == $past(pc_q) + XLEN'(4)));

  // R7: equal operands on beq land on the relative target
  a_r7_branch_target: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (opcode == OPC_BEQ && rs_val == rt_val) |=>
      (pc_q == $past(pc_q) + XLEN'(4) + {$past(imm_ext[XLEN-3:0]), 2'b00}));

  // R6: data writes only come from the store opcode
  a_r6_store_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dmem_we |-> (opcode == OPC_STORE));

  // R9: unknown opcodes change no architectural storage
  a_r9_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (opcode != OPC_RTYPE && opcode != OPC_LOAD && opcode != OPC_STORE &&
     opcode != OPC_BEQ) |-> (!rf_we && !dmem_we));

  // R1: PC held at zero while reset is asserted
  a_r1_reset_pc: assert property (@(posedge clk) !rst_n |-> (pc_q == '0));
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;

  logic [31:0] imem [32];
  logic [31:0] dmem [16];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sc_core u0 (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_re(dmem_re), .dmem_rdata(dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[6:2]];
  assign dmem_rdata = dmem[dmem_addr[5:2]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[5:2]] <= dmem_wdata;
  end

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'b00000, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  localparam logic [31:0] SENTINEL = 32'hDEAD_BEEF;
  logic [31:0] vals [8];

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h0000_0005;
    vals[6] = 32'h1234_5678; vals[7] = 32'hF0F0_F0F0;
    for (int i = 0; i < 32; i++) imem[i] = enc_i(6'b000100, 5'd0, 5'd0, 16'hFFFF);
    imem[0]  = enc_i(6'b100011, 5'd0, 5'd1, 16'd0);
    imem[1]  = enc_i(6'b100011, 5'd0, 5'd2, 16'd4);
    imem[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'b100000);
    imem[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'b100010);
    imem[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'b100100);
    imem[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'b100101);
    imem[6]  = enc_r(5'd1, 5'd2, 5'd7, 6'b101010);
    imem[7]  = enc_r(5'd2, 5'd1, 5'd8, 6'b101010);
    imem[8]  = enc_i(6'b101011, 5'd0, 5'd3, 16'd16);
    imem[9]  = enc_i(6'b101011, 5'd0, 5'd4, 16'd20);
    imem[10] = enc_i(6'b101011, 5'd0, 5'd5, 16'd24);
    imem[11] = enc_i(6'b101011, 5'd0, 5'd6, 16'd28);
    imem[12] = enc_i(6'b101011, 5'd0, 5'd7, 16'd32);
    imem[13] = enc_i(6'b101011, 5'd0, 5'd8, 16'd36);
    imem[14] = enc_r(5'd1, 5'd0, 5'd9, 6'b100000);
    imem[15] = enc_i(6'b000100, 5'd1, 5'd2, 16'd1);
    imem[16] = enc_r(5'd2, 5'd2, 5'd9, 6'b100000);
    imem[17] = enc_i(6'b101011, 5'd0, 5'd9, 16'd40);
    imem[18] = enc_r(5'd1, 5'd1, 5'd0, 6'b100000);
    imem[19] = enc_i(6'b101011, 5'd0, 5'd0, 16'd44);
    imem[20] = enc_i(6'b111111, 5'd0, 5'd1, 16'd48);
    imem[21] = enc_i(6'b100011, 5'd0, 5'd12, 16'd8);
    imem[22] = enc_i(6'b100011, 5'd12, 5'd11, 16'hFFFC);
    imem[23] = enc_i(6'b101011, 5'd0, 5'd11, 16'd52);
    imem[24] = enc_i(6'b000100, 5'd0, 5'd0, 16'hFFFF);

    rst_n = 1'b0;
    for (int ia = 0; ia < 8; ia++) begin
      for (int ib = 0; ib < 8; ib++) begin
        logic [31:0] a, b;
        a = vals[ia];
        b = vals[ib];
        @(negedge clk);
        rst_n = 1'b0;
        for (int k = 0; k < 16; k++) dmem[k] = 32'h0;
        dmem[0] = a; dmem[1] = b; dmem[2] = 32'd8; dmem[12] = SENTINEL;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset pc", imem_addr, 32'h0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check("R3 add", dmem[4], a + b);
        check("R3 sub", dmem[5], a - b);
        check("R3 and", dmem[6], a & b);
        check("R3 or", dmem[7], a | b);
        check("R4 slt a<b", dmem[8], ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        check("R4 slt b<a", dmem[9], ($signed(b) < $signed(a)) ? 32'd1 : 32'd0);
        check("R7 beq outcome", dmem[10], (a == b) ? a : b + b);
        check("R8 r0 write dropped", dmem[11], 32'h0);
        check("R9 unknown opcode no store", dmem[12], SENTINEL);
        check("R5 lw negative offset", dmem[13], b);
        check("R6 sw base word kept", dmem[0], a);
        check("R2 halt pc", imem_addr, 32'd96);
        @(negedge clk);
        check("R7 backward branch holds", imem_addr, 32'd96);
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule